// File: doc/BRIEF.md
# Multiplier-Based Shift and Rotate Unit

This execution unit produces 32-bit shifts and rotates on a pipelined 32x32 multiplier instead of a multiplexer barrel shifter. The shift amount is decoded into a one-hot power of two. The operand is multiplied by that value, and the result is then taken from the low half of the 64-bit unsigned product, from the high half, or from the OR of the two halves. A logical right shift by n multiplies by 2^(32-n) and keeps the high half. A rotate keeps the OR of both halves. An arithmetic right shift takes the logical result and ORs in a sign mask that covers the top n bits.

The same datapath also gives plain unsigned multiplies: the low word or the high word of the product. The unit accepts one operation on every clock cycle. Each result leaves after a fixed latency, together with a valid flag that travels with the data.

Top module: `mul_shift_unit`

## Requirements
- R1: `valid_o` is low while `rst_ni` is low. An operation sampled with `valid_i` high on a rising edge appears on `result_o` with `valid_o` high after the third rising edge, counting the sampling edge. On every other cycle `valid_o` is low.
- R2: Opcode 0 (multiply low) returns bits 31:0 of the unsigned product `opa_i` * `opb_i`.
- R3: Opcode 6 (multiply high) returns bits 63:32 of the unsigned product `opa_i` * `opb_i`.
- R4: Opcode 1 (logical left shift) returns `opa_i` shifted left by n, with zeros filled in from the bottom. Here n is `opb_i[4:0]`.
- R5: Opcode 2 (logical right shift) returns `opa_i` shifted right by n with zeros filled in from the top. For n = 0 it returns `opa_i` unchanged.
- R6: Opcode 3 (arithmetic right shift) returns `opa_i` shifted right by n, with copies of `opa_i[31]` filled in from the top.
- R7: Opcode 4 (rotate left) returns `opa_i` rotated left by n. A bit leaving at position 31 re-enters at position 0.
- R8: Opcode 5 (rotate right) returns `opa_i` rotated right by n. This equals a left rotate by (32 - n) mod 32.
- R9: For opcodes 1 to 5, only `opb_i[4:0]` sets the amount, and `opb_i[31:5]` has no effect on the result.
- R10: Opcode 7 is reserved and returns zero, with `valid_o` still following R1.
- R11: Operations issued on consecutive cycles each return their own result, in issue order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on the inputs |
| op_i | input | 3 | Opcode (0 mul-low, 1 sll, 2 srl, 3 sra, 4 rol, 5 ror, 6 mul-high, 7 reserved) |
| opa_i | input | 32 | Operand to shift, or the multiplicand |
| opb_i | input | 32 | Shift amount in bits 4:0, or the multiplier |
| valid_o | output | 1 | Result present |
| result_o | output | 32 | Result word |

## Verification
The shift opcodes are driven with amounts 0, 1, a middle value and 31. These tell apart the zero-amount bypass, a wrong choice of product half and an off-by-one in the power-of-two decode. Arithmetic shifts run on both negative and positive operands, which shows whether the sign mask is applied only when it should be. Amounts with their upper bits set test that the amount is truncated. Multiplies with all-ones operands exercise the carry into the high word. Finally, a back-to-back stream of mixed opcodes exposes any mixing of sideband data between pipeline stages.

// File: rtl/msu_pkg.sv
package msu_pkg;
  typedef enum logic [2:0] {
    OP_MULLO = 3'd0,
    OP_SLL   = 3'd1,
    OP_SRL   = 3'd2,
    OP_SRA   = 3'd3,
    OP_ROL   = 3'd4,
    OP_ROR   = 3'd5,
    OP_MULHI = 3'd6,
    OP_RSVD  = 3'd7
  } msu_op_e;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_OR   = 2'd2,
    SEL_ZERO = 2'd3
  } msu_sel_e;
endpackage

// File: rtl/msu_decode.sv
module msu_decode
  import msu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] mul_b_o,
  output msu_sel_e          sel_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [AMT_W-1:0]  amt;
  logic [AMT_W-1:0]  amt_neg;
  logic [AMT_W-1:0]  exp_sel;
  logic [DATA_W-1:0] pow2;
  logic              use_neg;
  logic              amt_zero;

  assign amt      = opb_i[AMT_W-1:0];
  assign amt_neg  = ~amt + AMT_W'(1);  // (DATA_W - n) mod DATA_W
  assign amt_zero = (amt == '0);
  assign use_neg  = (op_i == OP_SRL) || (op_i == OP_SRA) || (op_i == OP_ROR);
  assign exp_sel  = use_neg ? amt_neg : amt;

  // one-hot 2^k
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_pow2
    assign pow2[gi] = (exp_sel == AMT_W'(gi));
  end

  always_comb begin
    mul_b_o = pow2;
    sel_o   = SEL_LO;
    mask_o  = '0;
    unique case (msu_op_e'(op_i))
      OP_MULLO: mul_b_o = opb_i;
      OP_MULHI: begin mul_b_o = opb_i; sel_o = SEL_HI; end
      OP_SLL:   sel_o = SEL_LO;
      OP_SRL:   sel_o = amt_zero ? SEL_LO : SEL_HI;
      OP_SRA: begin
        sel_o = amt_zero ? SEL_LO : SEL_HI;
        if (opa_i[DATA_W-1]) mask_o = ~({DATA_W{1'b1}} >> amt);
      end
      OP_ROL, OP_ROR: sel_o = SEL_OR;
      default: begin mul_b_o = '0; sel_o = SEL_ZERO; end
    endcase
  end
endmodule

// File: rtl/msu_mult.sv
module msu_mult #(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [PROD_W-1:0] prod_d;

  assign prod_d = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= prod_d;
  end
endmodule

// File: rtl/msu_select.sv
module msu_select
  import msu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic [PROD_W-1:0] prod_i,
  input  msu_sel_e          sel_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] lo, hi, pick;

  assign lo = prod_i[DATA_W-1:0];
  assign hi = prod_i[PROD_W-1:DATA_W];

  always_comb begin
    unique case (sel_i)
      SEL_LO:  pick = lo;
      SEL_HI:  pick = hi;
      SEL_OR:  pick = lo | hi;
      default: pick = '0;
    endcase
  end

  assign res_o = pick | mask_i;
endmodule

// File: rtl/mul_shift_unit.sv
module mul_shift_unit
  import msu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  // stage 1: decoded operands
  logic [DATA_W-1:0] dec_b, dec_mask;
  msu_sel_e          dec_sel;
  logic              s1_vld;
  logic [DATA_W-1:0] s1_a, s1_b, s1_mask;
  msu_sel_e          s1_sel;
  // stage 2: product
  logic [PROD_W-1:0] s2_prod;
  logic              s2_vld;
  logic [DATA_W-1:0] s2_mask;
  msu_sel_e          s2_sel;
  logic [DATA_W-1:0] sel_res;

  msu_decode #(.DATA_W(DATA_W)) i_decode (
    .op_i   (op_i),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .mul_b_o(dec_b),
    .sel_o  (dec_sel),
    .mask_o (dec_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_mask <= '0;
      s1_sel  <= SEL_ZERO;
    end else begin
      s1_vld  <= valid_i;
      s1_a    <= opa_i;
      s1_b    <= dec_b;
      s1_mask <= dec_mask;
      s1_sel  <= dec_sel;
    end
  end

  msu_mult #(.DATA_W(DATA_W)) i_mult (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (s1_a),
    .b_i   (s1_b),
    .prod_o(s2_prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld  <= 1'b0;
      s2_mask <= '0;
      s2_sel  <= SEL_ZERO;
    end else begin
      s2_vld  <= s1_vld;
      s2_mask <= s1_mask;
      s2_sel  <= s1_sel;
    end
  end

  msu_select #(.DATA_W(DATA_W)) i_select (
    .prod_i(s2_prod),
    .sel_i (s2_sel),
    .mask_i(s2_mask),
    .res_o (sel_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= s2_vld;
      result_o <= sel_res;
    end
  end
endmodule

// File: rtl/msu_checker.sv
module msu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  logic [1:0] cyc;
  logic       hist_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end
  assign hist_ok = (cyc == 2'd3);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_ok |-> (valid_o == $past(valid_i, 3))); // R1

  AST_SLL_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && $past(valid_i, 3) && $past(op_i, 3) == 3'd1) |->
      ((result_o & ~({DATA_W{1'b1}} << $past(opb_i[4:0], 3))) == '0)); // R4

  AST_SRA_SIGN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && $past(valid_i, 3) && $past(op_i, 3) == 3'd3) |->
      (result_o[DATA_W-1] == $past(opa_i[DATA_W-1], 3))); // R6

  AST_ROTATE_ONES_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && $past(valid_i, 3) && ($past(op_i, 3) == 3'd4 || $past(op_i, 3) == 3'd5)) |->
      ($countones(result_o) == $countones($past(opa_i, 3)))); // R7

  AST_SRL_ZERO_IDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && $past(valid_i, 3) && $past(op_i, 3) == 3'd2 && $past(opb_i[4:0], 3) == 5'd0) |->
      (result_o == $past(opa_i, 3))); // R5

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && $past(valid_i, 3) && $past(op_i, 3) == 3'd7) |-> (result_o == '0)); // R10
endmodule

bind mul_shift_unit msu_checker #(.DATA_W(DATA_W)) i_msu_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/test_mul_shift_unit.sv
module test_mul_shift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  mul_shift_unit i_mul_shift_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .valid_o(valid_o), .result_o(result_o)
  );

  // batch of operations, issued back to back
  logic [2:0]  q_op[16];
  logic [31:0] q_a[16];
  logic [31:0] q_b[16];
  string       q_req[16];
  int          q_n = 0;

  function automatic logic [31:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    logic [63:0] p;
    int sh;
    p  = {32'd0, a} * {32'd0, b};
    sh = int'(b[4:0]);
    case (op)
      3'd0: return p[31:0];
      3'd1: return a << sh;
      3'd2: return a >> sh;
      3'd3: return $unsigned($signed(a) >>> sh);
      3'd4: return (a << sh) | (a >> (32 - sh));
      3'd5: return (a >> sh) | (a << (32 - sh));
      3'd6: return p[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [2:0] op, logic [31:0] a, logic [31:0] b, string req);
    q_op[q_n] = op; q_a[q_n] = a; q_b[q_n] = b; q_req[q_n] = req;
    q_n++;
  endtask

  // drive at negedge j, result visible at negedge j+3
  task automatic run_batch();
    for (int j = 0; j < q_n + 4; j++) begin
      @(negedge clk_i);
      if (j >= 3 && j - 3 < q_n) begin
        logic [31:0] e;
        e = model(q_op[j-3], q_a[j-3], q_b[j-3]);
        check(valid_o == 1'b1, "R1", "valid_o with result", 32'(valid_o), 32'd1);
        check(result_o == e, q_req[j-3], "result", result_o, e);
      end else begin
        check(valid_o == 1'b0, "R1", "valid_o idle", 32'(valid_o), 32'd0);
      end
      if (j < q_n) begin
        valid_i = 1'b1; op_i = q_op[j]; opa_i = q_a[j]; opb_i = q_b[j];
      end else begin
        valid_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0;
      end
    end
    q_n = 0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1", "valid_o in reset", 32'(valid_o), 32'd0);
    check(result_o == 32'd0, "R1", "result_o in reset", result_o, 32'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_mul();
    push(3'd0, 32'd3, 32'd5, "R2");
    push(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    push(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    push(3'd0, 32'h1234_5678, 32'h9ABC_DEF0, "R2");
    push(3'd6, 32'h1234_5678, 32'h9ABC_DEF0, "R3");
    run_batch();
  endtask

  task automatic t_left();
    push(3'd1, 32'hA5A5_0F0F, 32'd0, "R4");
    push(3'd1, 32'h8000_0001, 32'd1, "R4");
    push(3'd1, 32'hDEAD_BEEF, 32'd13, "R4");
    push(3'd1, 32'h0000_0003, 32'd31, "R4");
    push(3'd4, 32'h8000_0001, 32'd1, "R7");
    push(3'd4, 32'hDEAD_BEEF, 32'd0, "R7");
    push(3'd4, 32'h1234_5678, 32'd20, "R7");
    push(3'd4, 32'h0000_0003, 32'd31, "R7");
    run_batch();
  endtask

  task automatic t_right();
    push(3'd2, 32'hF00D_CAFE, 32'd0, "R5");
    push(3'd2, 32'hF00D_CAFE, 32'd4, "R5");
    push(3'd2, 32'h8000_0000, 32'd31, "R5");
    push(3'd3, 32'h8765_4321, 32'd8, "R6");
    push(3'd3, 32'h7654_3210, 32'd8, "R6");
    push(3'd3, 32'h8000_0000, 32'd31, "R6");
    push(3'd3, 32'h8765_4321, 32'd0, "R6");
    push(3'd5, 32'h1234_5678, 32'd0, "R8");
    push(3'd5, 32'h1234_5678, 32'd8, "R8");
    push(3'd5, 32'h8000_0001, 32'd31, "R8");
    run_batch();
  endtask

  task automatic t_amount_trunc();
    push(3'd1, 32'h0000_00FF, 32'hFFFF_FFE3, "R9");
    push(3'd2, 32'hFF00_0000, 32'h0000_0024, "R9");
    push(3'd3, 32'h8000_0000, 32'hABCD_EF05, "R9");
    push(3'd5, 32'h0000_000F, 32'hFFFF_FFE4, "R9");
    push(3'd4, 32'hC000_0000, 32'h0000_0021, "R9");
    run_batch();
  endtask

  task automatic t_reserved();
    push(3'd7, 32'hFFFF_FFFF, 32'h0000_0005, "R10");
    push(3'd7, 32'h1234_5678, 32'hFFFF_FFFF, "R10");
    run_batch();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 12; i++) begin
      push(3'(i % 7), 32'h9E37_79B9 * 32'(i + 1), 32'(i * 5 + 1), "R11");
    end
    run_batch();
  endtask

  initial begin
    t_reset();
    t_mul();
    t_left();
    t_right();
    t_amount_trunc();
    t_reserved();
    t_stream();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule